// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer

This block paces instruction flow for a small 8-bit accumulator processor. It divides the system clock into four phase strobes, one per clock and never two at once, and a full pass through all four strobes makes one instruction cycle. While the datapath decodes and executes one instruction word in the later three phases, the block fetches the next word from program memory in the first phase. A steady stream of ordinary instructions therefore completes at one per instruction cycle.

An external decoder looks at the instruction word the block presents and reports whether it redirects the program counter, together with the destination. The block acts on that report only on the execute strobe of a live instruction. The word it has already fetched from the next sequential address is then thrown away, that slot becomes an empty cycle, and the destination is fetched in the next first phase. A jump or call therefore costs exactly two instruction cycles. The datapath uses the phase strobes and a one-clock execute-enable pulse to time its register writes. A bubble flag marks every instruction cycle whose slot holds nothing.

Top module: `quad_phase_sequencer`

## Requirements
- R1: `phase` is one-hot at all times, with bit 0 meaning first phase through bit 3 meaning fourth phase. It advances by one bit per clock and returns from bit 3 to bit 0.
- R2: During the first phase, `pmemAddr` shows the program counter. On the clock edge that closes the first phase, the block captures `pmemData` and the counter advances by one. At no other point does it change, apart from a taken branch.
- R3: During the instruction cycle after a fetch, `instrOut` holds the word fetched in the first phase of the previous instruction cycle.
- R4: `execEn` is high for exactly the fourth-phase clock of an instruction cycle that is not a bubble, and low on every other clock.
- R5: A branch is taken when `isBranch` is high while `execEn` is high. The first-phase fetch of the next instruction cycle then uses the `branchTarget` value sampled on that clock, and that instruction cycle is a bubble. In the bench's instruction encoding, bit 11 marks a branch and bits 7:0 hold its target.
- R6: `isBranch` and `branchTarget` have no effect on a clock where `execEn` is low. This includes the first three phases and the fourth phase of a bubble.
- R7: While `rst` is high, the block shows the first phase, `pmemAddr` is 0, `bubble` is 1 and `execEn` is 0. The first instruction cycle after reset executes nothing.
- R8: `bubble` is constant across all four phases of an instruction cycle. It is high only in the first instruction cycle after reset and in the instruction cycle after a taken branch.
- R9: Counted from reset over K instruction cycles, the number of `execEn` pulses equals K, minus one, minus the number of branches taken before the last of those cycles.
- R10: The program counter wraps from its highest value to 0 during sequential fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pmemAddr | output | PC_W | Program memory address, valid in the first phase |
| pmemData | input | INSTR_W | Instruction word read from program memory |
| isBranch | input | 1 | Decoder flag: the word on `instrOut` redirects the program counter |
| branchTarget | input | PC_W | Destination address from the decoder |
| phase | output | 4 | One-hot phase strobes, first to fourth phase |
| instrOut | output | INSTR_W | Instruction word currently in the execute slot |
| execEn | output | 1 | One-clock execute pulse in the fourth phase of a live instruction |
| bubble | output | 1 | High for an instruction cycle whose execute slot is empty |

## Verification
A wrong internal state shows at the ports within one instruction cycle. A phase counter that slips makes `phase` and `execEn` wrong on the very next clock. A program counter that is wrong, or that is updated on the wrong clock, shows as a wrong `pmemAddr` at the next first phase. A pipeline valid bit that is wrong shows as an `execEn` pulse that is missing or extra, or as a `bubble` level that is wrong, in the same instruction cycle. The bench replays every run against an instruction-level model of the fetch and execute stream. It drives random noise on the decoder inputs whenever `execEn` is low, so any leak of those inputs shifts the next fetch address.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int NUM_PHASES = 4;
  localparam int PHASE_CNT_W = $clog2(NUM_PHASES);

  typedef struct packed {
    logic t1;
    logic t2;
    logic t3;
    logic t4;
  } phaseStrobes_t;
endpackage

// File: rtl/qps_phase_ctrl.sv
module qps_phase_ctrl
  import qps_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  output phaseStrobes_t strobes,
  output logic [NUM_PHASES-1:0] phaseVec
);
  logic [PHASE_CNT_W-1:0] phaseCnt;

  always_ff @(posedge clk) begin
    if (rst) phaseCnt <= '0;
    else     phaseCnt <= phaseCnt + 1'b1;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PHASES; gi++) begin : g_decode
      assign phaseVec[gi] = (phaseCnt == PHASE_CNT_W'(gi));
    end
  endgenerate

  assign strobes.t1 = phaseVec[0];
  assign strobes.t2 = phaseVec[1];
  assign strobes.t3 = phaseVec[2];
  assign strobes.t4 = phaseVec[3];

  generate
    for (gi = 0; gi < NUM_PHASES; gi++) begin : g_order
      // R1
      phase_order_chk: assert property (@(posedge clk) disable iff (rst)
        phaseVec[gi] |=> phaseVec[(gi + 1) % NUM_PHASES]);
    end
  endgenerate
endmodule

// File: rtl/qps_fetch_path.sv
module qps_fetch_path
  import qps_pkg::*;
#(
  parameter int PC_W    = 8,
  parameter int INSTR_W = 12
)(
  input  logic               clk,
  input  logic               rst,
  input  phaseStrobes_t      strobes,
  input  logic [INSTR_W-1:0] pmemData,
  input  logic               isBranch,
  input  logic [PC_W-1:0]    branchTarget,
  output logic [PC_W-1:0]    pmemAddr,
  output logic [INSTR_W-1:0] instrOut,
  output logic               execEn,
  output logic               bubble
);
  logic [PC_W-1:0]    pcReg;
  logic [INSTR_W-1:0] fetchBuf;
  logic [INSTR_W-1:0] irReg;
  logic               irValid;
  logic               takeBranch;

  assign takeBranch = strobes.t4 & irValid & isBranch;

  always_ff @(posedge clk) begin
    if (rst)             pcReg <= '0;
    else if (takeBranch) pcReg <= branchTarget;
    else if (strobes.t1) pcReg <= pcReg + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             fetchBuf <= '0;
    else if (strobes.t1) fetchBuf <= pmemData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irReg   <= '0;
      irValid <= 1'b0;
    end else if (strobes.t4) begin
      irReg   <= fetchBuf;
      irValid <= ~takeBranch;
    end
  end

  assign pmemAddr = pcReg;
  assign instrOut = irReg;
  assign execEn   = strobes.t4 & irValid;
  assign bubble   = ~irValid;

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.t1 && !takeBranch) |=> $stable(pcReg));

  // R5
  branch_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    takeBranch |=> (pcReg == $past(branchTarget)) && bubble && strobes.t1);

  // R8
  bubble_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.t4 |=> $stable(bubble));

  // R4
  exec_single_chk: assert property (@(posedge clk) disable iff (rst)
    execEn |=> !execEn && strobes.t1);
endmodule

// File: rtl/quad_phase_sequencer.sv
module quad_phase_sequencer
  import qps_pkg::*;
#(
  parameter int PC_W    = 8,
  parameter int INSTR_W = 12
)(
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    pmemAddr,
  input  logic [INSTR_W-1:0] pmemData,
  input  logic               isBranch,
  input  logic [PC_W-1:0]    branchTarget,
  output logic [3:0]         phase,
  output logic [INSTR_W-1:0] instrOut,
  output logic               execEn,
  output logic               bubble
);
  phaseStrobes_t strobes;
  logic [NUM_PHASES-1:0] phaseVec;

  qps_phase_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .phaseVec (phaseVec)
  );

  qps_fetch_path #(.PC_W(PC_W), .INSTR_W(INSTR_W)) u_path (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .pmemData     (pmemData),
    .isBranch     (isBranch),
    .branchTarget (branchTarget),
    .pmemAddr     (pmemAddr),
    .instrOut     (instrOut),
    .execEn       (execEn),
    .bubble       (bubble)
  );

  assign phase = phaseVec;
endmodule

// File: tb/quad_phase_sequencer_tb.sv
module quad_phase_sequencer_tb;
  localparam int PCW   = 8;
  localparam int IW    = 12;
  localparam int DEPTH = 1 << PCW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PCW-1:0] pmemAddr;
  logic [IW-1:0]  pmemData;
  logic           isBranch;
  logic [PCW-1:0] branchTarget;
  logic [3:0]     phase;
  logic [IW-1:0]  instrOut;
  logic           execEn;
  logic           bubble;

  logic [IW-1:0]  mem [DEPTH];
  logic           noiseBr = 1'b0;
  logic [PCW-1:0] noiseTgt = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int expFetch;
  int expExec;
  bit expBubble;
  bit lastWasBranch;

  always #2 clk = ~clk;

  assign pmemData     = mem[pmemAddr];
  assign isBranch     = phase[3] ? instrOut[11] : noiseBr;
  assign branchTarget = phase[3] ? instrOut[7:0] : noiseTgt;

  quad_phase_sequencer #(.PC_W(PCW), .INSTR_W(IW)) u_dut (
    .clk(clk), .rst(rst), .pmemAddr(pmemAddr), .pmemData(pmemData),
    .isBranch(isBranch), .branchTarget(branchTarget), .phase(phase),
    .instrOut(instrOut), .execEn(execEn), .bubble(bubble)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] plainWord(input int a);
    return {1'b0, 3'(a), 8'(a)};
  endfunction

  function automatic logic [IW-1:0] brWord(input int tgt);
    return {1'b1, 3'd5, 8'(tgt)};
  endfunction

  task automatic resetDut();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(phase == 4'b0001, "R7", "reset phase", phase, 1);
    chk(pmemAddr == '0, "R7", "reset pmemAddr", pmemAddr, 0);
    chk(bubble == 1'b1, "R7", "reset bubble", bubble, 1);
    chk(execEn == 1'b0, "R7", "reset execEn", execEn, 0);
    @(negedge clk);
    rst = 1'b0;
    expFetch = 0;
    expExec = 0;
    expBubble = 1'b1;
    lastWasBranch = 1'b0;
  endtask

  // Runs k instruction cycles right after resetDut, checking every clock.
  task automatic runCycles(input int k, input bit noisy);
    int dutExecs = 0;
    int modelBubbles = 0;
    int brEarly = 0;
    for (int c = 0; c < k; c++) begin
      if (expBubble) modelBubbles++;
      for (int p = 0; p < 4; p++) begin
        if (noisy) begin
          noiseBr  = 1'($urandom);
          noiseTgt = PCW'($urandom);
        end
        #1;
        chk(phase == 4'(1 << p), "R1", "phase strobe", phase, 1 << p);
        chk(execEn == (p == 3 && !expBubble), "R4", "execEn", execEn,
            int'(p == 3 && !expBubble));
        chk(bubble == expBubble, "R8", "bubble", bubble, expBubble);
        if (execEn) dutExecs++;
        if (p == 0) begin
          string tag;
          if (lastWasBranch) tag = "R5";
          else if (expBubble && c > 0) tag = "R6";
          else if (expFetch == 0 && c > 0) tag = "R10";
          else tag = "R2";
          chk(pmemAddr == PCW'(expFetch), tag, "fetch address", pmemAddr, expFetch);
        end
        if (p == 3 && !expBubble)
          chk(instrOut == mem[expExec], "R3", "instrOut", instrOut, mem[expExec]);
        if (p == 3) begin
          if (!expBubble && mem[expExec][11]) begin
            expBubble = 1'b1;
            expFetch = int'(mem[expExec][7:0]);
            lastWasBranch = 1'b1;
            if (c < k - 1) brEarly++;
          end else begin
            expBubble = 1'b0;
            expExec = expFetch;
            expFetch = (expFetch + 1) % DEPTH;
            lastWasBranch = 1'b0;
          end
        end
        @(negedge clk);
      end
    end
    chk(dutExecs == k - 1 - brEarly, "R9", "execute count", dutExecs, k - 1 - brEarly);
    chk(modelBubbles == 1 + brEarly, "R9", "bubble count", modelBubbles, 1 + brEarly);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // Random program with about one branch in five words.
    for (int a = 0; a < DEPTH; a++) begin
      logic [IW-1:0] w;
      w = IW'($urandom);
      w[11] = ($urandom % 5 == 0);
      mem[a] = w;
    end
    resetDut();
    runCycles(400, 1'b1);

    // Straight-line program: throughput and counter wrap.
    rst = 1'b1;
    for (int a = 0; a < DEPTH; a++) mem[a] = plainWord(a);
    resetDut();
    runCycles(300, 1'b1);

    // Directed: branch, stale branch word in the bubble, branch to next word.
    rst = 1'b1;
    for (int a = 0; a < DEPTH; a++) mem[a] = plainWord(a);
    mem[4]  = brWord(20);
    mem[5]  = brWord(99);
    mem[20] = brWord(21);
    mem[21] = brWord(4);
    resetDut();
    runCycles(30, 1'b1);

    // Reset taken mid-run, then a short quiet run.
    resetDut();
    runCycles(12, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule